// File: doc/BRIEF.md
# Serial ADC Host Read Controller

This block is the master side of a link to a 12-bit serial successive-approximation converter that uses a chip-select and a serial clock. It makes the serial clock by dividing the system clock and drives chip-select. It samples the 16-bit word the converter shifts out on each falling edge of the serial clock. It then presents the low 12 bits as the result, together with a one-cycle valid strobe and a flag for a malformed header.

The host issues requests on a simple command input. There are three request types. A full read returns a result. A short burst of 8 serial clocks puts the converter into power-down. A dummy 16-clock frame wakes it again; its data is discarded and the block waits long enough for the converter to power up. An interval timer can also start reads on its own, evenly spaced in whole serial-clock periods. Between frames the block holds chip-select high for at least the quiet and acquisition time the converter needs. While a frame or a gap is in progress, `busy` is high and new commands are dropped.

Top module: `adc_host_ctrl`

## Requirements
- R1: After reset, `cs_n` is 1, `sclk` is 1, `busy` is 0 and `result_valid` is 0. `sclk` stays at 1 whenever `cs_n` is 1.
- R2: A read frame holds `cs_n` low for exactly 16 serial periods (32·HALF_PER system cycles). `sclk` is high for the first HALF_PER cycles after `cs_n` falls. It then alternates low and high halves of HALF_PER cycles each, which gives exactly 16 falling edges, and returns high as `cs_n` rises.
- R3: The controller samples `sdata_in` at each falling edge of `sclk`, first bit first. In the cycle `cs_n` rises after a read, `result_valid` pulses for one cycle and `result` holds bits [11:0] of the 16-bit word.
- R4: `result_err` is 1 with the result when any of word bits [15:12] is 1, and 0 otherwise.
- R5: `cmd_op` = 2'b01 (power-down) gives a frame with exactly 8 `sclk` falling edges (16·HALF_PER cycles of `cs_n` low) and no `result_valid`.
- R6: `cmd_op` = 2'b10 (wake) gives a full 16-edge frame with no `result_valid`. `busy` then stays high for WAKE_CYC (default 200) cycles after `cs_n` rises.
- R7: After a read or power-down frame, `busy` stays high for the gap cycles after `cs_n` rises. The gap is QUIET_CYC, or the acquisition time not already covered by the end of the frame if that is longer (default 14 for both).
- R8: A command is taken only in a cycle where `busy` is 0. A `cmd_valid` pulse while `busy` is 1 is dropped, and `cmd_op` = 2'b11 never starts a frame. `cmd_op` = 2'b00 is a read.
- R9: With `timer_en` high and `sample_period` = P > 0, reads start every P·2·HALF_PER cycles. If a timer event falls while `busy` is 1, it is held and a read starts in the first cycle `busy` is 0.
- R10: When a timer event and `cmd_valid` arrive in the same idle cycle, the timed read starts and the command is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command request strobe |
| cmd_op | input | 2 | 00 read, 01 power-down, 10 wake, 11 none |
| timer_en | input | 1 | Enables timed reads |
| sample_period | input | PER_W | Timed-read interval in serial-clock periods |
| sdata_in | input | 1 | Serial data from the converter |
| sclk | output | 1 | Serial clock to the converter |
| cs_n | output | 1 | Active-low chip-select |
| busy | output | 1 | Frame or inter-frame gap in progress |
| result | output | RES_BITS | Last read result |
| result_valid | output | 1 | One-cycle strobe for a new result |
| result_err | output | 1 | Header bits of the last read were not zero |

## Verification
`cs_n` falls in the cycle after the edge that takes a command or timer event. `result_valid`, `result` and `result_err` are due 32·HALF_PER cycles later, in the same cycle `cs_n` rises. `busy` drops a gap's worth of cycles after that. A behavioural model in the bench advances one frame position per clock from these counts and is compared with every output at each falling clock edge. Extra checks count serial-clock edges per frame, busy cycles after each frame, and the spacing between timed chip-select falls, to confirm the held-event case of the timer.

// File: rtl/adc_host_pkg.sv
`timescale 1ns/1ps
package adc_host_pkg;

  typedef enum logic [1:0] {
    OP_READ  = 2'd0,
    OP_PWRDN = 2'd1,
    OP_WAKE  = 2'd2,
    OP_NONE  = 2'd3
  } host_op_e;

  function automatic int max_i(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  // cycles from the return to track mode until the end of the frame
  function automatic int tail_cycles(input int frame_bits, input int track_fall, input int half);
    return (2 * frame_bits - 2 * track_fall) * half;
  endfunction

  // gap after a read: quiet time, or uncovered acquisition time if longer
  function automatic int read_gap(input int quiet, input int acq, input int tail);
    return max_i(quiet, (acq > tail) ? acq - tail : 0);
  endfunction

endpackage

// File: rtl/adc_sample_timer.sv
`timescale 1ns/1ps
module adc_sample_timer #(
  parameter int HALF  = 10,
  parameter int PER_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [PER_W-1:0] period,
  input  logic             busy,
  output logic             req
);
  localparam int MUL  = 2 * HALF;
  localparam int TC_W = PER_W + $clog2(MUL) + 1;

  logic [TC_W-1:0] cnt, span;
  logic tick, pend;

  assign span = TC_W'(period) * TC_W'(MUL);
  assign tick = en && (period != '0) && (cnt >= span - TC_W'(1));
  assign req  = en && (tick || pend);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt  <= '0;
      pend <= 1'b0;
    end else begin
      if (!en || period == '0) cnt <= '0;
      else if (tick)           cnt <= '0;
      else                     cnt <= cnt + TC_W'(1);
      pend <= req && busy;
    end
  end

  // R9
  pend_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && busy) |=> pend);

endmodule

// File: rtl/adc_frame_seq.sv
`timescale 1ns/1ps
module adc_frame_seq #(
  parameter int HALF  = 10,
  parameter int NB_W  = 5,
  parameter int GAP_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [NB_W-1:0]  nbits,
  input  logic [GAP_W-1:0] gap_len,
  output logic             cs_n,
  output logic             sclk,
  output logic             busy,
  output logic             fall_evt,
  output logic             frame_end
);
  localparam int HC_W = $clog2(HALF + 1);
  localparam int HI_W = NB_W + 1;

  logic [HC_W-1:0]  half_cnt;
  logic [HI_W-1:0]  half_idx, last_half;
  logic [NB_W-1:0]  nb_q;
  logic [GAP_W-1:0] gap_q, gap_cnt;
  logic             in_frame, in_gap, half_done;

  // half 0 is the setup half; odd halves are low, even halves high
  assign last_half = {nb_q, 1'b0} - HI_W'(1);
  assign half_done = in_frame && (half_cnt == HC_W'(HALF - 1));
  assign frame_end = half_done && (half_idx == last_half);
  assign fall_evt  = half_done && !frame_end && !half_idx[0];
  assign busy      = in_frame || in_gap;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      in_frame <= 1'b0;
      in_gap   <= 1'b0;
      cs_n     <= 1'b1;
      sclk     <= 1'b1;
      half_cnt <= '0;
      half_idx <= '0;
      nb_q     <= '0;
      gap_q    <= '0;
      gap_cnt  <= '0;
    end else if (start && !busy) begin
      in_frame <= 1'b1;
      cs_n     <= 1'b0;
      sclk     <= 1'b1;
      half_cnt <= '0;
      half_idx <= '0;
      nb_q     <= nbits;
      gap_q    <= gap_len;
    end else if (in_frame) begin
      if (frame_end) begin
        in_frame <= 1'b0;
        in_gap   <= 1'b1;
        gap_cnt  <= '0;
        cs_n     <= 1'b1;
        sclk     <= 1'b1;
        half_cnt <= '0;
      end else if (half_done) begin
        half_cnt <= '0;
        half_idx <= half_idx + HI_W'(1);
        sclk     <= ~sclk;
      end else begin
        half_cnt <= half_cnt + HC_W'(1);
      end
    end else if (in_gap) begin
      if (gap_cnt == gap_q - GAP_W'(1)) in_gap  <= 1'b0;
      else                              gap_cnt <= gap_cnt + GAP_W'(1);
    end
  end

  // R2
  setup_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cs_n) |-> sclk);
  // R1
  idle_sclk_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> sclk);
  // R7
  gap_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cs_n) |-> busy);

endmodule

// File: rtl/adc_word_capture.sv
`timescale 1ns/1ps
module adc_word_capture #(
  parameter int FRAME_BITS = 16,
  parameter int RES_BITS   = 12
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                sample,
  input  logic                bit_in,
  input  logic                done,
  input  logic                keep,
  output logic [RES_BITS-1:0] result,
  output logic                res_valid,
  output logic                res_err
);
  logic [FRAME_BITS-1:0] shreg;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      shreg     <= '0;
      result    <= '0;
      res_valid <= 1'b0;
      res_err   <= 1'b0;
    end else begin
      res_valid <= done && keep;
      if (sample) shreg <= {shreg[FRAME_BITS-2:0], bit_in};
      if (done && keep) begin
        result  <= shreg[RES_BITS-1:0];
        res_err <= |shreg[FRAME_BITS-1:RES_BITS];
      end
    end
  end

endmodule

// File: rtl/adc_host_ctrl.sv
`timescale 1ns/1ps
module adc_host_ctrl #(
  parameter int HALF_PER   = 10,
  parameter int FRAME_BITS = 16,
  parameter int RES_BITS   = 12,
  parameter int PD_BITS    = 8,
  parameter int TRACK_FALL = 13,
  parameter int QUIET_CYC  = 14,
  parameter int ACQ_CYC    = 58,
  parameter int WAKE_CYC   = 200,
  parameter int PER_W      = 12
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cmd_valid,
  input  logic [1:0]          cmd_op,
  input  logic                timer_en,
  input  logic [PER_W-1:0]    sample_period,
  input  logic                sdata_in,
  output logic                sclk,
  output logic                cs_n,
  output logic                busy,
  output logic [RES_BITS-1:0] result,
  output logic                result_valid,
  output logic                result_err
);
  import adc_host_pkg::*;

  localparam int TAIL_CYC = tail_cycles(FRAME_BITS, TRACK_FALL, HALF_PER);
  localparam int RD_GAP   = read_gap(QUIET_CYC, ACQ_CYC, TAIL_CYC);
  localparam int PD_GAP   = max_i(QUIET_CYC, 1);
  localparam int WK_GAP   = max_i(WAKE_CYC, RD_GAP);
  localparam int GAP_W    = $clog2(max_i(WK_GAP, PD_GAP) + 1);
  localparam int NB_W     = $clog2(FRAME_BITS + 1);

  logic             timer_req, start, fall_evt, frame_end;
  host_op_e         sel_op, op_q;
  logic [NB_W-1:0]  sel_bits;
  logic [GAP_W-1:0] sel_gap;

  adc_sample_timer #(.HALF(HALF_PER), .PER_W(PER_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .en(timer_en), .period(sample_period),
    .busy(busy), .req(timer_req));

  // timed read wins over a command arriving in the same cycle
  assign sel_op = timer_req ? OP_READ : host_op_e'(cmd_op);
  assign start  = !busy && (timer_req || (cmd_valid && cmd_op != OP_NONE));

  always_comb begin
    sel_bits = NB_W'(FRAME_BITS);
    sel_gap  = GAP_W'(RD_GAP);
    case (sel_op)
      OP_PWRDN: begin sel_bits = NB_W'(PD_BITS); sel_gap = GAP_W'(PD_GAP); end
      OP_WAKE:  sel_gap = GAP_W'(WK_GAP);
      default:  ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n)     op_q <= OP_READ;
    else if (start) op_q <= sel_op;
  end

  adc_frame_seq #(.HALF(HALF_PER), .NB_W(NB_W), .GAP_W(GAP_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .nbits(sel_bits), .gap_len(sel_gap),
    .cs_n(cs_n), .sclk(sclk), .busy(busy), .fall_evt(fall_evt), .frame_end(frame_end));

  adc_word_capture #(.FRAME_BITS(FRAME_BITS), .RES_BITS(RES_BITS)) u_cap (
    .clk(clk), .rst_n(rst_n), .sample(fall_evt), .bit_in(sdata_in),
    .done(frame_end), .keep(op_q == OP_READ),
    .result(result), .res_valid(result_valid), .res_err(result_err));

  // R3
  valid_on_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    result_valid |-> $rose(cs_n));
  // R3
  valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    result_valid |=> !result_valid);
  // R8
  no_start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cs_n) |-> !$past(busy));

endmodule

// File: tb/adc_host_ctrl_tb.sv
`timescale 1ns/1ps
module adc_host_ctrl_tb;
  localparam int H     = 10;
  localparam int RDG   = 14;
  localparam int PDG   = 14;
  localparam int WKG   = 200;

  logic clk = 1'b0, rst_n = 1'b0, cmd_valid = 1'b0, timer_en = 1'b0;
  logic [1:0] cmd_op = 2'd0;
  logic [11:0] sample_period = '0;
  logic sdata, sclk, cs_n, busy, result_valid, result_err;
  logic [11:0] result;
  logic [15:0] adc_word = 16'h0000;

  int n_cmp = 0, n_bad = 0, cyc = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  adc_host_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .timer_en(timer_en), .sample_period(sample_period), .sdata_in(sdata),
    .sclk(sclk), .cs_n(cs_n), .busy(busy), .result(result),
    .result_valid(result_valid), .result_err(result_err));

  // converter model: shifts the word out, one bit per sclk falling edge
  int fc = 0, last_falls = 0;
  always @(negedge sclk or posedge cs_n) begin
    if (cs_n) begin
      if (fc != 0) last_falls <= fc;
      fc <= 0;
    end else fc <= fc + 1;
  end
  assign sdata = (!cs_n && fc < 16) ? adc_word[15 - fc] : 1'b1;

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int lvl(input int j);
    if (j < H) return 1;
    return (((j - H) / H) % 2 == 0) ? 0 : 1;
  endfunction

  // behavioural reference model, advanced once per rising edge
  int m_act = 0, m_j = 0, m_len = 0, m_gap = 0, m_op = 0, m_valid = 0;
  int m_res = 0, m_err = 0, tc = 0, pend = 0;
  logic [15:0] m_word = '0;

  always @(posedge clk) begin
    cyc++;
    if (!rst_n) begin
      m_act = 0; m_j = 0; m_valid = 0; tc = 0; pend = 0; m_res = 0; m_err = 0;
    end else begin
      int busy_pre, tick, want, pc;
      busy_pre = m_act;
      m_valid = 0;
      if (m_act != 0) begin
        m_j++;
        if (m_j == m_len + m_gap) m_act = 0;
        else if (m_j == m_len && m_op == 0) begin
          m_valid = 1;
          m_res = int'(m_word) % 4096;
          m_err = (int'(m_word) / 4096 != 0) ? 1 : 0;
        end
      end
      tick = 0;
      if (timer_en && sample_period != 0) begin
        pc = int'(sample_period) * 2 * H;
        tick = (tc >= pc - 1) ? 1 : 0;
        tc = (tick != 0) ? 0 : tc + 1;
      end else tc = 0;
      want = (timer_en && (tick != 0 || pend != 0)) ? 1 : 0;
      pend = (want != 0 && busy_pre != 0) ? 1 : 0;
      if (busy_pre == 0) begin
        int op;
        op = -1;
        if (want != 0) op = 0;
        else if (cmd_valid && cmd_op != 2'd3) op = int'(cmd_op);
        if (op >= 0) begin
          m_act = 1; m_j = 0; m_op = op; m_word = adc_word;
          m_len = ((op == 1) ? 8 : 16) * 2 * H;
          m_gap = (op == 0) ? RDG : (op == 1) ? PDG : WKG;
        end
      end
    end
  end

  // per-cycle comparison and monitors
  int vcnt = 0, last_res = 0, last_err = 0, gc = 0, last_gap = 0, fidx = 0;
  int ft [64];
  logic prev_cs = 1'b1;
  always @(negedge clk) begin
    if (rst_n && !done) begin
      int in_f;
      in_f = (m_act != 0 && m_j < m_len) ? 1 : 0;
      chk("R2", "cs_n", int'(cs_n), 1 - in_f);
      chk("R2", "sclk", int'(sclk), (in_f != 0) ? lvl(m_j) : 1);
      chk("R7", "busy", int'(busy), m_act);
      chk("R3", "result_valid", int'(result_valid), m_valid);
      if (m_valid != 0) begin
        chk("R3", "result", int'(result), m_res);
        chk("R4", "result_err", int'(result_err), m_err);
      end
    end
    if (result_valid) begin vcnt++; last_res = int'(result); last_err = int'(result_err); end
    if (busy && cs_n) gc++;
    else if (!busy) begin if (gc != 0) last_gap = gc; gc = 0; end
    if (prev_cs && !cs_n) begin if (fidx < 64) ft[fidx] = cyc; fidx++; end
    prev_cs = cs_n;
  end

  task automatic start_cmd(input logic [1:0] op, input logic [15:0] w);
    @(negedge clk);
    adc_word = w; cmd_op = op; cmd_valid = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic wait_idle();
    while (busy) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic do_read(input logic [15:0] w, input int exp_res, input int exp_err, input string rq);
    int v0;
    v0 = vcnt;
    start_cmd(2'd0, w);
    wait_idle();
    chk("R2", "falls per read", last_falls, 16);
    chk("R3", "valid count", vcnt - v0, 1);
    chk(rq, "result", last_res, exp_res);
    chk("R4", "err", last_err, exp_err);
    chk("R7", "read gap", last_gap, RDG);
  endtask

  initial begin
    int v0, b0;
    repeat (4) @(negedge clk);
    chk("R1", "reset cs_n", int'(cs_n), 1);
    chk("R1", "reset sclk", int'(sclk), 1);
    chk("R1", "reset busy", int'(busy), 0);
    chk("R1", "reset valid", int'(result_valid), 0);
    rst_n = 1'b1;
    @(negedge clk);

    do_read(16'h0ABC, 12'hABC, 0, "R3");
    do_read(16'h0FFF, 12'hFFF, 0, "R3");
    do_read(16'h0000, 0, 0, "R3");
    do_read(16'h5123, 12'h123, 1, "R4");
    do_read(16'h8001, 1, 1, "R4");

    // R5 power-down burst
    v0 = vcnt;
    start_cmd(2'd1, 16'h0FFF);
    wait_idle();
    chk("R5", "falls per power-down", last_falls, 8);
    chk("R5", "no valid", vcnt - v0, 0);
    chk("R7", "power-down gap", last_gap, PDG);

    // R6 wake frame
    v0 = vcnt;
    start_cmd(2'd2, 16'h0555);
    wait_idle();
    chk("R6", "falls per wake", last_falls, 16);
    chk("R6", "no valid", vcnt - v0, 0);
    chk("R6", "wake gap", last_gap, WKG);

    // R8 command while busy is dropped
    v0 = vcnt;
    start_cmd(2'd0, 16'h0321);
    repeat (100) @(negedge clk);
    cmd_op = 2'd1; cmd_valid = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0;
    wait_idle();
    chk("R8", "falls of running read", last_falls, 16);
    chk("R8", "result kept", last_res, 12'h321);
    repeat (5) @(negedge clk);
    chk("R8", "no queued frame", int'(busy), 0);

    // R8 op 11 starts nothing
    start_cmd(2'd3, 16'h0111);
    repeat (5) @(negedge clk);
    chk("R8", "op11 busy", int'(busy), 0);
    chk("R8", "op11 cs_n", int'(cs_n), 1);

    // R9 / R10 timed reads, command collides with the first timer event
    adc_word = 16'h0123;
    b0 = fidx;
    sample_period = 12'd20; timer_en = 1'b1;
    repeat (399) @(negedge clk);
    cmd_op = 2'd1; cmd_valid = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0;
    while (!cs_n) @(negedge clk);
    @(negedge clk);
    chk("R10", "timed frame is a read", last_falls, 16);
    while (fidx < b0 + 3) @(negedge clk);
    timer_en = 1'b0;
    wait_idle();
    chk("R9", "spacing 1", ft[b0 + 1] - ft[b0], 400);
    chk("R9", "spacing 2", ft[b0 + 2] - ft[b0 + 1], 400);
    chk("R9", "timed result", last_res, 12'h123);

    // R9 event held while busy: interval shorter than frame plus gap
    b0 = fidx;
    sample_period = 12'd15; timer_en = 1'b1;
    while (fidx < b0 + 3) @(negedge clk);
    timer_en = 1'b0;
    wait_idle();
    chk("R9", "held spacing 1", ft[b0 + 1] - ft[b0], 32 * H + RDG + 1);
    chk("R9", "held spacing 2", ft[b0 + 2] - ft[b0 + 1], 32 * H + RDG + 1);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual %0d expected %0d", 150000, 0);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

endmodule